// File: doc/BRIEF.md
# Hamming Chunk Corrector

This unit settles the outcome of one 512-byte data chunk protected by a 24-bit single-error-correcting Hamming code. It receives two codes: the one kept in the flash spare area and the one recomputed while the chunk was read. It spreads both codes into a 32-bit working layout and XORs them into a syndrome. The number of set syndrome bits decides the outcome: clean, one correctable data bit, a damaged code, an erased page, or an uncorrectable error.

For a correctable error the unit repairs the chunk in place. It sends one read request for the failing byte to an external byte-wide chunk buffer. On the next cycle it writes that byte back with the failing bit inverted. A one-cycle done pulse reports the result on a 3-bit status code.

Top module: `ham_chunk_fixer`

## Requirements
- R1: Each code is taken as three bytes: first byte on bits 7:0, second on 15:8, third on 23:16. It is spread into 32 bits: the first byte goes to 7:0, the second to 23:16, the upper nibble of the third to 27:24 and its lower nibble to 11:8. All other bits are zero.
- R2: If both spread codes are equal, status_o is 0 (clean) and the buffer is neither read nor written.
- R3: If the syndrome (the XOR of the two spread codes) has exactly 12 ones, status_o is 1 (corrected). Syndrome bits 18:16 give the bit number and bits 27:19 give the byte address.
- R4: A correction reads the addressed byte and writes back that byte XOR a one-hot mask of the bit number. No other byte changes.
- R5: A syndrome with exactly one set bit gives status_o 2 (damaged code) and no buffer access.
- R6: A stored spread code of 0x0FFF0FFF with a recomputed spread code of 0 gives status_o 3 (erased) and no buffer access.
- R7: Any other nonzero syndrome gives status_o 4 (uncorrectable) and no buffer access.
- R8: done_o is high for exactly one cycle. It comes in the second cycle after the edge that samples start_i, or in the fourth when a correction is made. status_o is valid with done_o and stays unchanged while the unit is idle.
- R9: A correction raises buf_rd_o for one cycle and then buf_wr_o for one cycle at the same address. Read data is taken one cycle after the read request.
- R10: start_i and both codes are ignored while busy_o is high. busy_o is high from the cycle after an accepted start through the done cycle.
- R11: While rst_n is low at a clock edge, the unit returns to idle with busy_o, done_o, buf_rd_o and buf_wr_o low and status_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin evaluation of one chunk |
| stored_ecc_i | input | 24 | Code read from the spare area |
| calc_ecc_i | input | 24 | Code recomputed over the chunk |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | Outcome code |
| buf_rd_o | output | 1 | Chunk buffer read request |
| buf_wr_o | output | 1 | Chunk buffer write request |
| buf_addr_o | output | 9 | Byte address within the chunk |
| buf_wdata_o | output | 8 | Corrected byte to write |
| buf_rdata_i | input | 8 | Byte returned one cycle after a read request |

## Verification
The outcome is due two cycles after the start edge. A repair adds two cycles, one for the read and one for the write, so done_o comes four cycles after start. The bench drives on falling edges and samples on every falling edge after start. It records the exact cycle in which done_o first appears and compares it against 2 or 4. It then checks that done_o is low on the following falling edge. The buffer model counts read and write requests per operation and compares all 512 bytes once done_o has been seen.

// File: rtl/ham_fix_pkg.sv
// Shared types and constants for the Hamming chunk corrector.
// Assumes 24-bit codes covering a 512-byte chunk with byte-wide access.
package ham_fix_pkg;

    // Outcome codes reported on the status output
    typedef enum logic [2:0] {
        FIX_CLEAN   = 3'd0,
        FIX_FIXED   = 3'd1,
        FIX_CODEBAD = 3'd2,
        FIX_BLANK   = 3'd3,
        FIX_MULTI   = 3'd4
    } fix_status_e;

    localparam int unsigned CODE_W    = 24;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned PAIR_ONES = 12;
    localparam logic [WORD_W-1:0] BLANK_SIG = 32'h0FFF_0FFF;

endpackage

// File: rtl/ham_code_expand.sv
// Spreads one packed 3-byte code into the 32-bit working layout.
// Assumes input bytes ordered low to high; unused positions are zero.
module ham_code_expand #(
    parameter int unsigned CW = 24,
    parameter int unsigned WW = 32
) (
    input  logic [CW-1:0] code_i,
    output logic [WW-1:0] word_o
);
    // Place each byte and nibble at its position in the spread word
    always_comb begin
        word_o        = '0;
        word_o[7:0]   = code_i[7:0];
        word_o[23:16] = code_i[15:8];
        word_o[11:8]  = code_i[19:16];
        word_o[27:24] = code_i[23:20];
    end
endmodule

// File: rtl/ham_syndrome_classify.sv
// Forms the syndrome of two spread codes and decides the chunk outcome.
// Assumes spread layout from ham_code_expand; purely combinational.
module ham_syndrome_classify
    import ham_fix_pkg::*;
#(
    parameter int unsigned WW      = 32,
    parameter int unsigned ADDR_W  = 9,
    parameter int unsigned BIT_W   = 3,
    parameter int unsigned IDX_LSB = 16
) (
    input  logic [WW-1:0]     stored_w_i,
    input  logic [WW-1:0]     calc_w_i,
    output fix_status_e       verdict_o,
    output logic [ADDR_W-1:0] corr_addr_o,
    output logic [BIT_W-1:0]  corr_bit_o
);
    localparam int unsigned POP_W = $clog2(WW + 1);

    logic [WW-1:0]    syn;
    logic [POP_W-1:0] ones;

    // Syndrome and population count of its set bits
    always_comb begin
        syn  = stored_w_i ^ calc_w_i;
        ones = '0;
        for (int i = 0; i < int'(WW); i++) begin
            ones = ones + POP_W'(syn[i]);
        end
    end

    // Outcome decision in priority order
    always_comb begin
        if (syn == '0)
            verdict_o = FIX_CLEAN;
        else if (ones == POP_W'(PAIR_ONES))
            verdict_o = FIX_FIXED;
        else if (ones == POP_W'(1))
            verdict_o = FIX_CODEBAD;
        else if (stored_w_i == WW'(BLANK_SIG) && calc_w_i == '0)
            verdict_o = FIX_BLANK;
        else
            verdict_o = FIX_MULTI;
    end

    // Failing byte and bit taken from the upper parity half
    assign corr_bit_o  = syn[IDX_LSB +: BIT_W];
    assign corr_addr_o = syn[IDX_LSB + BIT_W +: ADDR_W];
endmodule

// File: rtl/ham_fix_ctrl.sv
// Sequencer: accepts a start, latches the verdict and runs the one-byte
// read-modify-write for a correction. Assumes buffer read latency of 1.
module ham_fix_ctrl
    import ham_fix_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  fix_status_e       verdict_i,
    input  logic [ADDR_W-1:0] corr_addr_i,
    input  logic [BIT_W-1:0]  corr_bit_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              cap_en_o,
    output logic              busy_o,
    output logic              done_o,
    output fix_status_e       status_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    typedef enum logic [2:0] {
        S_IDLE, S_EVAL, S_RD, S_WR, S_FIN
    } seq_e;

    seq_e              state;
    fix_status_e       status_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] mask_q;

    // State, verdict, address and flip mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            status_q <= FIX_CLEAN;
            addr_q   <= '0;
            mask_q   <= '0;
        end else begin
            case (state)
                S_IDLE: if (start_i) state <= S_EVAL;
                S_EVAL: begin
                    status_q <= verdict_i;
                    addr_q   <= corr_addr_i;
                    mask_q   <= {{(DATA_W-1){1'b0}}, 1'b1} << corr_bit_i;
                    state    <= (verdict_i == FIX_FIXED) ? S_RD : S_FIN;
                end
                S_RD:    state <= S_WR;
                S_WR:    state <= S_FIN;
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Decoded outputs
    always_comb begin
        cap_en_o = (state == S_IDLE) && start_i;
        busy_o   = (state != S_IDLE);
        done_o   = (state == S_FIN);
        rd_o     = (state == S_RD);
        wr_o     = (state == S_WR);
        addr_o   = addr_q;
        wdata_o  = rdata_i ^ mask_q;
        status_o = status_q;
    end
endmodule

// File: rtl/ham_chunk_fixer.sv
// Top: captures both codes on start, spreads them, classifies the
// syndrome and drives the chunk buffer for a single-bit repair.
// Assumes a byte-wide buffer with one-cycle read latency.
module ham_chunk_fixer
    import ham_fix_pkg::*;
#(
    parameter int unsigned CHUNK_BYTES = 512,
    parameter int unsigned DATA_W      = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [23:0]                    stored_ecc_i,
    input  logic [23:0]                    calc_ecc_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic [2:0]                     status_o,
    output logic                           buf_rd_o,
    output logic                           buf_wr_o,
    output logic [$clog2(CHUNK_BYTES)-1:0] buf_addr_o,
    output logic [DATA_W-1:0]              buf_wdata_o,
    input  logic [DATA_W-1:0]              buf_rdata_i
);
    localparam int unsigned ADDR_W = $clog2(CHUNK_BYTES);
    localparam int unsigned BIT_W  = $clog2(DATA_W);
    localparam int unsigned NCODES = 2;

    logic [CODE_W-1:0] code_q [NCODES];
    logic [WORD_W-1:0] word_w [NCODES];
    logic              cap_en;
    fix_status_e       verdict;
    fix_status_e       status_e;
    logic [ADDR_W-1:0] corr_addr;
    logic [BIT_W-1:0]  corr_bit;

    // Capture both codes when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q[0] <= '0;
            code_q[1] <= '0;
        end else if (cap_en) begin
            code_q[0] <= stored_ecc_i;
            code_q[1] <= calc_ecc_i;
        end
    end

    // One spreader per code
    for (genvar g = 0; g < NCODES; g++) begin : g_expand
        ham_code_expand #(.CW(CODE_W), .WW(WORD_W)) u_exp (
            .code_i (code_q[g]),
            .word_o (word_w[g])
        );
    end

    ham_syndrome_classify #(
        .WW(WORD_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W), .IDX_LSB(16)
    ) u_cls (
        .stored_w_i  (word_w[0]),
        .calc_w_i    (word_w[1]),
        .verdict_o   (verdict),
        .corr_addr_o (corr_addr),
        .corr_bit_o  (corr_bit)
    );

    ham_fix_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .verdict_i   (verdict),
        .corr_addr_i (corr_addr),
        .corr_bit_i  (corr_bit),
        .rdata_i     (buf_rdata_i),
        .cap_en_o    (cap_en),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .status_o    (status_e),
        .rd_o        (buf_rd_o),
        .wr_o        (buf_wr_o),
        .addr_o      (buf_addr_o),
        .wdata_o     (buf_wdata_o)
    );

    assign status_o = status_e;
endmodule

// File: rtl/ham_chunk_fixer_chk.sv
// Protocol checker for ham_chunk_fixer, attached by bind.
module ham_chunk_fixer_chk #(
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [2:0]        status_o,
    input logic              buf_rd_o,
    input logic              buf_wr_o,
    input logic [ADDR_W-1:0] buf_addr_o
);
    // R9
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_o |=> buf_wr_o);
    // R9
    same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_o |=> $stable(buf_addr_o));
    // R9
    wr_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_o |-> $past(buf_rd_o));
    // R9
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_o && buf_wr_o));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(status_o));
    // R10
    busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
    // R4
    fixed_wrote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 3'd1) |-> $past(buf_wr_o));
    // R7
    other_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o != 3'd1) |-> !$past(buf_wr_o));
endmodule

bind ham_chunk_fixer ham_chunk_fixer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .status_o   (status_o),
    .buf_rd_o   (buf_rd_o),
    .buf_wr_o   (buf_wr_o),
    .buf_addr_o (buf_addr_o)
);

// File: tb/tb_ham_chunk_fixer.sv
module tb_ham_chunk_fixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] stored_ecc_i = '0;
    logic [23:0] calc_ecc_i = '0;
    logic        busy_o, done_o, buf_rd_o, buf_wr_o;
    logic [2:0]  status_o;
    logic [8:0]  buf_addr_o;
    logic [7:0]  buf_wdata_o;
    logic [7:0]  buf_rdata_i = '0;

    always #5 clk = ~clk;

    ham_chunk_fixer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .stored_ecc_i(stored_ecc_i), .calc_ecc_i(calc_ecc_i),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
        .buf_rd_o(buf_rd_o), .buf_wr_o(buf_wr_o), .buf_addr_o(buf_addr_o),
        .buf_wdata_o(buf_wdata_o), .buf_rdata_i(buf_rdata_i)
    );

    int tests = 0;
    int fails = 0;
    int rds = 0;
    int wrs = 0;
    logic [7:0] mem [512];
    logic [7:0] ref_mem [512];

    // buffer model: one-cycle read latency, write on edge
    always @(posedge clk) begin
        if (buf_rd_o) begin buf_rdata_i <= mem[buf_addr_o]; rds <= rds + 1; end
        if (buf_wr_o) begin mem[buf_addr_o] <= buf_wdata_o; wrs <= wrs + 1; end
    end

    // {stored, calc, status, byte, bit}
    localparam int NV = 14;
    localparam logic [62:0] VECS [NV] = '{
        {24'h3C3C3C, 24'h3C3C3C, 3'd0, 9'd0,   3'd0},
        {24'h000000, 24'h000000, 3'd0, 9'd0,   3'd0},
        {24'h123456, 24'h1D1F82, 3'd1, 9'd5,   3'd3},
        {24'h000000, 24'hF0FF00, 3'd1, 9'd511, 3'd7},
        {24'hA5A5A5, 24'hAAA55A, 3'd1, 9'd0,   3'd0},
        {24'h000000, 24'h8702FD, 3'd1, 9'd256, 3'd2},
        {24'h000001, 24'h000000, 3'd2, 9'd0,   3'd0},
        {24'h800000, 24'h000000, 3'd2, 9'd0,   3'd0},
        {24'hFFFFFF, 24'h000000, 3'd3, 9'd0,   3'd0},
        {24'h000000, 24'hFFFFFF, 3'd4, 9'd0,   3'd0},
        {24'h000003, 24'h000000, 3'd4, 9'd0,   3'd0},
        {24'h0007FF, 24'h000000, 3'd4, 9'd0,   3'd0},
        {24'h001FFF, 24'h000000, 3'd4, 9'd0,   3'd0},
        {24'hFFFFFF, 24'h000001, 3'd4, 9'd0,   3'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] st);
        case (st)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
    endtask

    // start one operation, return latency in cycles after the start edge
    task automatic run_op(input logic [23:0] st, input logic [23:0] ca, output int lat);
        @(negedge clk);
        rds = 0; wrs = 0;
        stored_ecc_i = st; calc_ecc_i = ca; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic mem_diff(output int bad);
        bad = 0;
        for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) bad++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lat, bad;
        logic [2:0] est;
        fill_mem();
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy_o && !done_o && !buf_rd_o && !buf_wr_o && status_o == 3'd0,
              "R11 reset", {busy_o, done_o, buf_rd_o, buf_wr_o, status_o}, 0);
        rst_n = 1'b1;

        // table of vectors
        for (int v = 0; v < NV; v++) begin
            est = VECS[v][14:12];
            fill_mem();
            if (est == 3'd1)
                ref_mem[VECS[v][11:3]] ^= 8'(1 << VECS[v][2:0]);
            run_op(VECS[v][62:39], VECS[v][38:15], lat);
            check(status_o == est, req_of(est), status_o, est);
            check(lat == ((est == 3'd1) ? 4 : 2), "R8 latency", lat, (est == 3'd1) ? 4 : 2);
            check(rds == ((est == 3'd1) ? 1 : 0) && wrs == rds, "R9 accesses",
                  rds * 16 + wrs, (est == 3'd1) ? 17 : 0);
            mem_diff(bad);
            check(bad == 0, (est == 3'd1) ? "R4 data" : req_of(est), bad, 0);
            @(negedge clk);
            check(!done_o, "R8 pulse", done_o, 0);
        end

        // R8 status held while idle
        repeat (3) @(negedge clk);
        check(status_o == 3'd4, "R8 hold", status_o, 4);

        // R1 byte placement: error at byte 511 bit 7 needs third-byte high nibble
        fill_mem();
        ref_mem[511] ^= 8'h80;
        run_op(24'hF0FF00, 24'h000000, lat);
        mem_diff(bad);
        check(status_o == 3'd1 && bad == 0, "R1 layout", bad, 0);

        // R10 start held and codes changed while busy
        fill_mem();
        ref_mem[5] ^= 8'h08;
        @(negedge clk);
        rds = 0; wrs = 0;
        stored_ecc_i = 24'h123456; calc_ecc_i = 24'h1D1F82; start_i = 1'b1;
        @(negedge clk);
        stored_ecc_i = 24'h000001; calc_ecc_i = 24'h000000;
        lat = 1;
        while (!done_o && lat < 20) begin @(negedge clk); lat++; end
        start_i = 1'b0;
        check(status_o == 3'd1 && lat == 4, "R10 status", status_o, 1);
        mem_diff(bad);
        check(bad == 0 && wrs == 1, "R10 data", bad, 0);
        @(negedge clk);
        check(!busy_o && !done_o, "R10 idle", {busy_o, done_o}, 0);
        repeat (3) @(negedge clk);
        check(!busy_o && status_o == 3'd1, "R10 no restart", status_o, 1);

        // R11 reset in the middle of a correction
        @(negedge clk);
        stored_ecc_i = 24'h123456; calc_ecc_i = 24'h1D1F82; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !buf_rd_o && !buf_wr_o && status_o == 3'd0,
              "R11 mid reset", {busy_o, done_o, buf_rd_o, buf_wr_o, status_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule